// File: doc/BRIEF.md
# Three-Wire Serial Byte Shifter

This block moves one byte at a time over a three-wire synchronous link made of a serial clock, a data input and a data output. An external master drives the serial clock. Before a transfer, software writes the byte to send into the data register and clears the edge counter. On every serial clock cycle the engine takes in one bit and sends out one bit, most significant bit first. After eight serial clock cycles the outgoing byte has been replaced by the incoming byte, which software reads back in parallel.

The serial clock and data input come from outside the system clock domain. Each passes through a two-stage synchroniser, and serial clock edges are found from the synchronised copy. A mode input chooses which edge captures the data input and which edge advances the register. The two settings match the SPI data modes with clock phase 0 and phase 1. A 4-bit counter advances on every serial clock edge of either polarity. When it wraps after sixteen edges it sets a sticky completion flag, which is also driven onto a wake request output.

Top module: `tw_shift_engine`

## Requirements
- R1: While `rst_n` is low and after its release, `edge_count` is 0, `done_flag` and `wake_req` are 0, `rd_data` is 0x00 and `sdo` is 0.
- R2: With `mode` = 0, a rising edge of `sck` captures `sdi` into a one-bit holding stage, and a falling edge shifts the data register left by one, with the held bit entering at bit 0.
- R3: With `mode` = 1, the edges are swapped: a falling `sck` edge captures `sdi` and a rising edge shifts the register.
- R4: `sdo` always equals bit 7 of the data register, so the byte leaves MSB first. After eight capture and shift pairs, `rd_data` holds the eight captured bits, with the first captured bit in bit 7.
- R5: `edge_count` increments by one on every detected `sck` edge, rising or falling, in either mode. It does not change when no edge is detected.
- R6: An edge detected while `edge_count` is 15 wraps the counter to 0 and sets `done_flag`. `wake_req` always equals `done_flag`.
- R7: `done_flag` stays at 1 until `flag_clr` is high on a clock edge. If an overflow happens in that same cycle, the flag stays set.
- R8: `cnt_clr` high on a clock edge sets `edge_count` to 0 and clears `done_flag`. This takes priority over an edge detected in the same cycle.
- R9: `wr_en` high on a clock edge loads `wr_data` into the data register. This takes priority over a shift detected in the same cycle.
- R10: `sck` and `sdi` each pass through two flip-flops. A level change on `sck` that is set up before clock edge k takes effect at clock edge k+2. `sck` must hold each level for at least two `clk` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 1 | Edge select: 0 = capture on rising, shift on falling; 1 = swapped |
| sck | input | 1 | Serial clock from the link master |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output (register MSB) |
| wr_en | input | 1 | Parallel load strobe for the data register |
| wr_data | input | 8 | Byte to load |
| rd_data | output | 8 | Current data register contents |
| cnt_clr | input | 1 | Clear edge counter and completion flag |
| flag_clr | input | 1 | Clear completion flag (write-one) |
| edge_count | output | 4 | Serial clock edge counter |
| done_flag | output | 1 | Sticky transfer-complete flag |
| wake_req | output | 1 | Interrupt / wake request, mirrors the flag |

## Verification
The hardest cases to reach from the ports are the ones where two events land on the same system clock edge: a parallel write meeting a detected shift edge, a flag clear meeting the sixteenth edge, and a counter clear meeting an edge. All three depend on the two-cycle synchroniser delay. The stimulus changes `sck` and then raises the strobe exactly two clock edges later, so both hit the same cycle. A behavioural model built on history queues tracks every cycle, and directed checks confirm the priority outcome at the ports after each collision.

// File: rtl/tw_shift_engine.sv
module tw_shift_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode,
  input  logic       sck,
  input  logic       sdi,
  output logic       sdo,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       cnt_clr,
  input  logic       flag_clr,
  output logic [3:0] edge_count,
  output logic       done_flag,
  output logic       wake_req
);

  logic [2:0] sck_sync;
  logic [1:0] sdi_sync;
  logic [7:0] data_q;
  logic       hold_q;
  logic [3:0] cnt_q;
  logic       flag_q;

  // R10: two-flop synchronisers plus one stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync <= '0;
      sdi_sync <= '0;
    end else begin
      sck_sync <= {sck_sync[1:0], sck};
      sdi_sync <= {sdi_sync[0], sdi};
    end
  end

  wire rise_ev  =  sck_sync[1] & ~sck_sync[2];
  wire fall_ev  = ~sck_sync[1] &  sck_sync[2];
  wire any_ev   = rise_ev | fall_ev;
  wire sample_ev = mode ? fall_ev : rise_ev;
  wire shift_ev  = mode ? rise_ev : fall_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (sample_ev) hold_q <= sdi_sync[1];
      if (wr_en)         data_q <= wr_data;
      else if (shift_ev) data_q <= {data_q[6:0], hold_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (cnt_clr) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (any_ev) cnt_q <= cnt_q + 4'd1;
      if (any_ev && cnt_q == 4'hF) flag_q <= 1'b1;
      else if (flag_clr)           flag_q <= 1'b0;
    end
  end

  assign sdo        = data_q[7];
  assign rd_data    = data_q;
  assign edge_count = cnt_q;
  assign done_flag  = flag_q;
  assign wake_req   = flag_q;

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && sck_sync[1] != sck_sync[2]) |=> (cnt_q == $past(cnt_q) + 4'd1));

  assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && sck_sync[1] == sck_sync[2]) |=> $stable(cnt_q));

  assert_overflow_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && any_ev && cnt_q == 4'hF) |=> (flag_q && cnt_q == 4'h0));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr && !cnt_clr) |=> flag_q);

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_q == 4'h0 && !flag_q));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (data_q == $past(wr_data)));

  assert_mode0_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !wr_en && !sck_sync[1] && sck_sync[2]) |=> (data_q[0] == $past(hold_q)));

endmodule

// File: tb/tb_tw_shift_engine.sv
`timescale 1ns/1ps
module tb_tw_shift_engine;
  logic clk = 0, rst_n = 0, mode = 0, sck = 0, sdi = 0;
  logic wr_en = 0, cnt_clr = 0, flag_clr = 0;
  logic [7:0] wr_data = 0;
  logic sdo, done_flag, wake_req;
  logic [7:0] rd_data;
  logic [3:0] edge_count;

  int checks = 0, failures = 0;
  bit finished = 0;

  tw_shift_engine dut (.clk(clk), .rst_n(rst_n), .mode(mode), .sck(sck), .sdi(sdi),
    .sdo(sdo), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .cnt_clr(cnt_clr),
    .flag_clr(flag_clr), .edge_count(edge_count), .done_flag(done_flag), .wake_req(wake_req));

  always #2 clk = ~clk;

  // behavioural reference
  bit sck_h[$] = '{0, 0, 0};
  bit sdi_h[$] = '{0, 0, 0};
  int m_cnt = 0;
  bit m_flag = 0, m_hold = 0;
  bit [7:0] m_data = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_flag = 0; m_hold = 0; m_data = 0;
      sck_h = '{0, 0, 0}; sdi_h = '{0, 0, 0};
    end else begin
      bit up, dn, smp, shf;
      up = sck_h[1] && !sck_h[2];
      dn = !sck_h[1] && sck_h[2];
      smp = mode ? dn : up;
      shf = mode ? up : dn;
      if (wr_en) m_data = wr_data;
      else if (shf) m_data = {m_data[6:0], m_hold};
      if (smp) m_hold = sdi_h[1];
      if (cnt_clr) begin m_cnt = 0; m_flag = 0; end
      else begin
        if (up || dn) begin
          if (m_cnt == 15) m_flag = 1;
          else if (flag_clr) m_flag = 0;
          m_cnt = (m_cnt + 1) % 16;
        end else if (flag_clr) m_flag = 0;
      end
      sck_h.push_front(sck); void'(sck_h.pop_back());
      sdi_h.push_front(sdi); void'(sdi_h.pop_back());
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    check("R4", "sdo", sdo, m_data[7]);
    check("R2", "rd_data", rd_data, m_data);
    check("R5", "edge_count", edge_count, m_cnt);
    check("R6", "done_flag", done_flag, m_flag);
    check("R6", "wake_req", wake_req, m_flag);
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input bit [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b; cnt_clr = 1;
    @(negedge clk); wr_en = 0; cnt_clr = 0;
  endtask

  // one byte: 16 edges, each level held 4 clocks; rx driven MSB first
  task automatic xfer(input bit m, input bit [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sdi = rx[i];
      clks(4); sck = ~sck;
      clks(4); sck = ~sck;
    end
    clks(6);
  endtask

  initial begin
    clks(3);
    check("R1", "reset count", edge_count, 0);
    check("R1", "reset flag", done_flag, 0);
    check("R1", "reset data", rd_data, 0);
    check("R1", "reset sdo", sdo, 0);
    rst_n = 1;
    clks(2);
    check("R1", "post-reset wake", wake_req, 0);

    // mode 0, idle low
    mode = 0; sck = 0;
    load(8'hA5);
    check("R4", "sdo MSB before first edge", sdo, 1);
    xfer(0, 8'h3C);
    check("R2", "mode0 received", rd_data, 8'h3C);
    check("R6", "flag after 16 edges", done_flag, 1);
    check("R6", "count wrapped", edge_count, 0);

    // sticky
    clks(10);
    check("R7", "flag sticky", done_flag, 1);
    @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
    check("R7", "flag cleared", done_flag, 0);

    // mode 1, idle high
    mode = 1; sck = 1; clks(6);
    load(8'h5A);
    xfer(1, 8'hC9);
    check("R3", "mode1 received", rd_data, 8'hC9);
    check("R6", "mode1 flag", done_flag, 1);

    // R10 latency: one edge counted only at the third clock edge
    mode = 0; sck = 0; clks(6);
    load(8'h00);
    @(negedge clk); sck = 1;
    @(posedge clk); @(posedge clk); #1;
    check("R10", "not yet counted", edge_count, 0);
    @(posedge clk); #1;
    check("R10", "counted after sync", edge_count, 1);
    check("R5", "rising counted", edge_count, 1);
    clks(4);

    // R9: write coincides with falling (shift) edge
    @(negedge clk); sck = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1; wr_data = 8'h81;
    @(negedge clk); wr_en = 0;
    check("R9", "write beats shift", rd_data, 8'h81);
    check("R5", "falling counted", edge_count, 2);

    // R8: counter clear coincides with an edge
    clks(4);
    @(negedge clk); sck = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); cnt_clr = 1;
    @(negedge clk); cnt_clr = 0;
    check("R8", "clear beats edge", edge_count, 0);

    // R7: flag_clr coincides with overflow edge
    clks(4);
    sck = 1; load(8'hF0);
    for (int i = 0; i < 15; i++) begin sck = ~sck; clks(4); end
    check("R5", "fifteen edges", edge_count, 15);
    @(negedge clk); sck = ~sck;
    @(posedge clk); @(posedge clk);
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    check("R7", "overflow beats flag_clr", done_flag, 1);
    check("R6", "wrap to zero", edge_count, 0);

    // R8: cnt_clr clears a set flag
    @(negedge clk); cnt_clr = 1; @(negedge clk); cnt_clr = 0;
    check("R8", "cnt_clr clears flag", done_flag, 0);

    // another mode-0 byte pattern
    sck = 0; clks(6);
    load(8'hFF);
    xfer(0, 8'h01);
    check("R4", "received LSB pattern", rd_data, 8'h01);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule